// File: doc/BRIEF.md
# Critical-Word-First Cache Line-Fill Controller

This block sits behind a small cache and handles the core's fetch requests. A request that is cacheable while the cache is switched on is looked up in the tag store and in a 16-byte fill buffer. A request that hits either one is answered one cycle after it is taken. Any other request becomes an external read. That read fetches either a whole 16-byte line or a single longword. The choice depends on the request type, a 2-bit fill-size setting and the longword offset of the miss.

A line read starts at the requested longword and continues upward through the line, wrapping at the 16-byte boundary. The first longword returned goes straight back to the core. The fill buffer and the tag store collect the others. When the last beat arrives, the line is marked valid in both, so later accesses to it hit. A control write sets the enable bit and the fill-size field, and can trigger a one-shot invalidate of every stored line. Reset clears the control settings, so the cache starts switched off. Reset does not touch the tag store, so software must invalidate before it enables the cache.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: After reset, the cache is disabled: `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. A cacheable request then goes external as a single longword (`mem_req_line`=0) and returns the memory word at its address.
- R2: A control write with `cfg_inval_in`=1 clears every stored line and the fill buffer. A later access to a line that used to hit then goes external.
- R3: While enabled, a cacheable request that hits the tag store or the fill buffer is answered on the cycle after acceptance with the stored word, and makes no external request.
- R4: An enabled, cacheable data miss (`req_instr`=0) always fetches a full line (`mem_req_line`=1).
- R5: An enabled, cacheable instruction miss fetches a full line or a single longword according to the fill-size field and miss offset (address bits [3:2]). Fill-size 00 always gives a line. Fill-size 01 gives a single longword only at offset 3. Fill-size 1x gives a single longword at offsets 2 and 3.
- R6: `mem_req_addr` is the miss address with bits [1:0] cleared, and it is held stable until `mem_req_ready`. Beat k of a line read carries the longword at offset (miss offset + k) mod 4 of that line.
- R7: A completed line read leaves the line valid, so every longword of it then hits with the correct data.
- R8: A single-longword read, a non-cacheable request and any request while disabled never allocate a line. Repeating such a request goes external again.
- R9: The first returned beat is presented on `rsp_data` with `rsp_valid`=1 on the following cycle, before the line read has finished.
- R10: `req_ready` stays 0 from the acceptance of a miss until the cycle after its last beat.
- R11: If an invalidate is written while a read is in progress, the read still completes and answers the core, but its line is left invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_enable_in | input | 1 | Cache enable value written |
| cfg_inval_in | input | 1 | One-shot invalidate of all lines when written as 1 |
| cfg_fsz_in | input | 2 | Instruction fill-size setting written |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | AW | Request byte address |
| req_instr | input | 1 | 1 for instruction fetch, 0 for data |
| req_cacheable | input | 1 | Request may use the cache |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW | Response longword |
| mem_req_valid | output | 1 | External read request |
| mem_req_ready | input | 1 | External read request taken |
| mem_req_addr | output | AW | Address of the first longword to return |
| mem_req_line | output | 1 | 1 for a four-beat wrapped line, 0 for one beat |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DW | Read beat data |

## Verification
The hardest case to reach from the ports is an invalidate that lands in the middle of a line read. The bench issues a line miss and waits until the first read beat is visible on `mem_rvalid`. It then writes the invalidate in that same cycle, so the control write falls between the first and last beats. A later access to the same line must then go external. Ordering is checked without looking inside: the memory model returns distinct words, and reads of the other longwords must hit with those words.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned WSEL_BITS  = $clog2(LINE_WORDS);
  localparam int unsigned OFF_BITS   = WSEL_BITS + 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } fill_st_e;

  // Full line or single longword for a miss that may use the cache.
  function automatic logic fill_wants_line(input logic instr,
                                           input logic [1:0] fsz,
                                           input logic [WSEL_BITS-1:0] off);
    logic r;
    if (!instr)               r = 1'b1;
    else if (fsz == 2'b00)    r = 1'b1;
    else if (fsz == 2'b01)    r = (off != 2'b11);
    else                      r = (off[1] == 1'b0);
    return r;
  endfunction

  // Longword slot that beat number 'beat' of a wrapped read lands in.
  function automatic logic [WSEL_BITS-1:0] wrap_off(input logic [WSEL_BITS-1:0] crit,
                                                    input logic [WSEL_BITS-1:0] beat);
    return crit + beat;
  endfunction

endpackage

// File: rtl/cwf_tag_store.sv
module cwf_tag_store
  import cwf_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned NSETS = 8
) (
  input  logic                          clk,
  input  logic                          inval_all,
  input  logic [AW-OFF_BITS-1:0]        lk_line,
  input  logic [WSEL_BITS-1:0]          lk_word,
  output logic                          lk_hit,
  output logic [DW-1:0]                 lk_data,
  input  logic                          wr_en,
  input  logic [AW-OFF_BITS-1:0]        wr_line,
  input  logic [WSEL_BITS-1:0]          wr_word,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          clr_en,
  input  logic [AW-OFF_BITS-1:0]        clr_line,
  input  logic                          set_en,
  input  logic [AW-OFF_BITS-1:0]        set_line
);
  localparam int unsigned IDXW = (NSETS > 1) ? $clog2(NSETS) : 1;
  localparam int unsigned TAGW = AW - OFF_BITS - IDXW;

  logic [NSETS-1:0] valid_q;
  logic [TAGW-1:0]  tag_q  [NSETS];
  logic [DW-1:0]    data_q [NSETS][LINE_WORDS];

  logic [IDXW-1:0] lk_idx, wr_idx, clr_idx, set_idx;
  assign lk_idx  = lk_line[IDXW-1:0];
  assign wr_idx  = wr_line[IDXW-1:0];
  assign clr_idx = clr_line[IDXW-1:0];
  assign set_idx = set_line[IDXW-1:0];

  logic unused_tag_bits;
  assign unused_tag_bits = &{1'b0, clr_line[AW-OFF_BITS-1:IDXW], wr_line[AW-OFF_BITS-1:IDXW]};

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_line[AW-OFF_BITS-1:IDXW]);
  assign lk_data = data_q[lk_idx][lk_word];

  // Valid bits are deliberately not reset: contents survive reset.
  generate
    for (genvar s = 0; s < NSETS; s++) begin : g_set
      always_ff @(posedge clk) begin
        if (inval_all) begin
          valid_q[s] <= 1'b0;
        end else if (clr_en && clr_idx == IDXW'(s)) begin
          valid_q[s] <= 1'b0;
        end else if (set_en && set_idx == IDXW'(s)) begin
          valid_q[s] <= 1'b1;
        end
        if (set_en && set_idx == IDXW'(s)) begin
          tag_q[s] <= set_line[AW-OFF_BITS-1:IDXW];
        end
        if (wr_en && wr_idx == IDXW'(s)) begin
          data_q[s][wr_word] <= wr_data;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cwf_fill_buf.sv
module cwf_fill_buf
  import cwf_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   drop,
  input  logic                   wr_en,
  input  logic [WSEL_BITS-1:0]   wr_word,
  input  logic [DW-1:0]          wr_data,
  input  logic                   commit,
  input  logic [AW-OFF_BITS-1:0] commit_line,
  input  logic [AW-OFF_BITS-1:0] lk_line,
  input  logic [WSEL_BITS-1:0]   lk_word,
  output logic                   lk_hit,
  output logic [DW-1:0]          lk_data,
  output logic                   buf_valid
);
  logic                   valid_q;
  logic [AW-OFF_BITS-1:0] line_q;
  logic [DW-1:0]          words_q [LINE_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      line_q  <= '0;
    end else if (drop) begin
      valid_q <= 1'b0;
    end else if (commit) begin
      valid_q <= 1'b1;
      line_q  <= commit_line;
    end
  end

  generate
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (wr_en && wr_word == WSEL_BITS'(w)) begin
          words_q[w] <= wr_data;
        end
      end
    end
  endgenerate

  assign lk_hit    = valid_q && (line_q == lk_line);
  assign lk_data   = words_q[lk_word];
  assign buf_valid = valid_q;

endmodule

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq
  import cwf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_line,
  input  logic                 mem_req_ready,
  input  logic                 mem_rvalid,
  output logic                 idle,
  output logic                 mem_req_valid,
  output logic                 beat_fire,
  output logic                 beat_first,
  output logic                 beat_last,
  output logic [WSEL_BITS-1:0] beat_idx
);
  fill_st_e               st_q;
  logic                   line_q;
  logic [WSEL_BITS-1:0]   beat_q;

  assign idle          = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ADDR);
  assign beat_fire     = (st_q == ST_DATA) && mem_rvalid;
  assign beat_first    = beat_fire && (beat_q == '0);
  assign beat_last     = beat_fire && (!line_q || beat_q == WSEL_BITS'(LINE_WORDS - 1));
  assign beat_idx      = beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      line_q <= 1'b0;
      beat_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_ADDR;
          line_q <= start_line;
          beat_q <= '0;
        end
        ST_ADDR: if (mem_req_ready) st_q <= ST_DATA;
        ST_DATA: if (beat_fire) begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
  import cwf_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned NSETS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_enable_in,
  input  logic          cfg_inval_in,
  input  logic [1:0]    cfg_fsz_in,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_instr,
  input  logic          req_cacheable,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_line,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int unsigned LW = AW - OFF_BITS;

  // Control register
  logic       cfg_en_q;
  logic [1:0] cfg_fsz_q;
  logic       inval_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en_q  <= 1'b0;
      cfg_fsz_q <= 2'b00;
    end else if (cfg_we) begin
      cfg_en_q  <= cfg_enable_in;
      cfg_fsz_q <= cfg_fsz_in;
    end
  end
  assign inval_now = cfg_we && cfg_inval_in;

  // Request decode
  logic [LW-1:0]        req_line;
  logic [WSEL_BITS-1:0] req_word;
  logic                 unused_lsbs;
  assign req_line    = req_addr[AW-1:OFF_BITS];
  assign req_word    = req_addr[OFF_BITS-1:2];
  assign unused_lsbs = &{1'b0, req_addr[1:0]};

  logic seq_idle, beat_fire, beat_first, beat_last;
  logic [WSEL_BITS-1:0] beat_idx;
  logic tag_hit, lfb_hit, lfb_valid;
  logic [DW-1:0] tag_data, lfb_data;

  logic req_fire, use_cache, hit_any, acc_hit, acc_miss, miss_line;
  assign req_ready = seq_idle;
  assign req_fire  = req_valid && req_ready;
  assign use_cache = cfg_en_q && req_cacheable;
  assign hit_any   = use_cache && (tag_hit || lfb_hit);
  assign acc_hit   = req_fire && hit_any;
  assign acc_miss  = req_fire && !hit_any;
  assign miss_line = use_cache && fill_wants_line(req_instr, cfg_fsz_q, req_word);

  // Outstanding read context
  logic [LW-1:0]        cur_line_q;
  logic [WSEL_BITS-1:0] cur_word_q;
  logic                 cur_fill_q;
  logic                 inval_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_line_q   <= '0;
      cur_word_q   <= '0;
      cur_fill_q   <= 1'b0;
      inval_seen_q <= 1'b0;
    end else if (acc_miss) begin
      cur_line_q   <= req_line;
      cur_word_q   <= req_word;
      cur_fill_q   <= miss_line;
      inval_seen_q <= 1'b0;
    end else if (inval_now && !seq_idle) begin
      inval_seen_q <= 1'b1;
    end
  end

  assign mem_req_addr = {cur_line_q, cur_word_q, 2'b00};
  assign mem_req_line = cur_fill_q;

  // Beat placement and completion
  logic [WSEL_BITS-1:0] beat_word;
  logic                 fill_wr;
  logic                 commit_line;
  assign beat_word   = wrap_off(cur_word_q, beat_idx);
  assign fill_wr     = beat_fire && cur_fill_q;
  assign commit_line = beat_last && cur_fill_q && !inval_seen_q && !inval_now;

  cwf_fill_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (acc_miss),
    .start_line    (miss_line),
    .mem_req_ready (mem_req_ready),
    .mem_rvalid    (mem_rvalid),
    .idle          (seq_idle),
    .mem_req_valid (mem_req_valid),
    .beat_fire     (beat_fire),
    .beat_first    (beat_first),
    .beat_last     (beat_last),
    .beat_idx      (beat_idx)
  );

  cwf_tag_store #(.AW(AW), .DW(DW), .NSETS(NSETS)) u_tags (
    .clk       (clk),
    .inval_all (inval_now),
    .lk_line   (req_line),
    .lk_word   (req_word),
    .lk_hit    (tag_hit),
    .lk_data   (tag_data),
    .wr_en     (fill_wr),
    .wr_line   (cur_line_q),
    .wr_word   (beat_word),
    .wr_data   (mem_rdata),
    .clr_en    (acc_miss && miss_line),
    .clr_line  (req_line),
    .set_en    (commit_line),
    .set_line  (cur_line_q)
  );

  cwf_fill_buf #(.AW(AW), .DW(DW)) u_lfb (
    .clk         (clk),
    .rst_n       (rst_n),
    .drop        (inval_now || (acc_miss && miss_line)),
    .wr_en       (fill_wr),
    .wr_word     (beat_word),
    .wr_data     (mem_rdata),
    .commit      (commit_line),
    .commit_line (cur_line_q),
    .lk_line     (req_line),
    .lk_word     (req_word),
    .lk_hit      (lfb_hit),
    .lk_data     (lfb_data),
    .buf_valid   (lfb_valid)
  );

  // Response: hit data or the first returned beat
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= acc_hit || beat_first;
      if (acc_hit)         rsp_data_q <= lfb_hit ? lfb_data : tag_data;
      else if (beat_first) rsp_data_q <= mem_rdata;
    end
  end
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/cwf_fill_ctrl_chk.sv
module cwf_fill_ctrl_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_req_line,
  input logic          acc_hit,
  input logic          acc_miss,
  input logic          req_instr,
  input logic          req_cacheable,
  input logic          cfg_en_q,
  input logic [1:0]    cfg_fsz_q,
  input logic          beat_first,
  input logic          beat_last,
  input logic          commit_line,
  input logic          lfb_valid,
  input logic          inval_now
);

  AST_INVAL_DROPS_LFB: assert property (@(posedge clk) disable iff (!rst_n)
    inval_now |=> !lfb_valid); // R2

  AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> rsp_valid && !mem_req_valid); // R3

  AST_DATA_FULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss && cfg_en_q && req_cacheable && !req_instr |=> mem_req_line); // R4

  AST_FSZ_ZERO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss && cfg_en_q && req_cacheable && req_instr && cfg_fsz_q == 2'b00 |=> mem_req_line); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R6

  AST_LINE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_line |=> lfb_valid); // R7

  AST_BYPASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss && !(cfg_en_q && req_cacheable) |=> !mem_req_line); // R8

  AST_CRIT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    beat_first && !beat_last |=> rsp_valid && !req_ready); // R9

  AST_STALL_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R10

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> !req_ready); // R10

endmodule

bind cwf_fill_ctrl cwf_fill_ctrl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_line  (mem_req_line),
  .acc_hit       (acc_hit),
  .acc_miss      (acc_miss),
  .req_instr     (req_instr),
  .req_cacheable (req_cacheable),
  .cfg_en_q      (cfg_en_q),
  .cfg_fsz_q     (cfg_fsz_q),
  .beat_first    (beat_first),
  .beat_last     (beat_last),
  .commit_line   (commit_line),
  .lfb_valid     (lfb_valid),
  .inval_now     (inval_now)
);

// File: tb/tb_cwf_fill_ctrl.sv
`timescale 1ns/1ps
module tb_cwf_fill_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_enable_in = 1'b0, cfg_inval_in = 1'b0;
  logic [1:0]  cfg_fsz_in = 2'b00;
  logic        req_valid = 1'b0, req_instr = 1'b0, req_cacheable = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, mem_req_valid, mem_req_line;
  logic [31:0] rsp_data, mem_req_addr;
  logic        mem_req_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  cwf_fill_ctrl dut (.*);

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Memory model: request monitor plus beat driver
  int          nreq = 0;
  int          served = 0;
  logic [31:0] last_addr = '0;
  logic        last_line = 1'b0;

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      nreq      <= nreq + 1;
      last_addr <= mem_req_addr;
      last_line <= mem_req_line;
    end
  end

  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (nreq != served) begin
        served = nreq;
        mem_req_ready = 1'b0;
        wcnt = 0;
        @(negedge clk);
        for (int k = 0; k < (last_line ? 4 : 1); k++) begin
          if (k == 2) begin
            mem_rvalid = 1'b0;
            @(negedge clk);
          end
          mem_rvalid = 1'b1;
          mem_rdata  = memf({last_addr[31:4], 2'(last_addr[3:2] + 2'(k)), 2'b00});
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end else if (mem_req_valid) begin
        wcnt++;
        mem_req_ready = (wcnt >= 2);
      end else begin
        wcnt = 0;
        mem_req_ready = 1'b0;
      end
    end
  end

  task automatic cfg(input logic en, input logic inv, input logic [1:0] fsz);
    @(negedge clk);
    cfg_we = 1'b1; cfg_enable_in = en; cfg_inval_in = inv; cfg_fsz_in = fsz;
    @(negedge clk);
    cfg_we = 1'b0; cfg_inval_in = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic ins, input logic cch,
                        output logic [31:0] d, output logic ext, output logic line,
                        output logic rdy_at_rsp);
    int n0 = nreq;
    int g = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_instr = ins; req_cacheable = cch;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && g < 200) begin @(negedge clk); g++; end
    d = rsp_data;
    rdy_at_rsp = req_ready;
    while (!req_ready && g < 400) begin @(negedge clk); g++; end
    ext  = (nreq != n0);
    line = last_line;
  endtask

  // Table: addr, instr, cacheable, expect external, expect line
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {32'h0000_1008, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_100C, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'h0000_2024, 1'b1, 1'b1, 1'b1, 1'b1},
    {32'h0000_1004, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_303C, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0000_3030, 1'b1, 1'b1, 1'b1, 1'b1},
    {32'h0000_4000, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_4000, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_2028, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_4008, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic ext, line, rr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    access(32'h0000_1008, 1'b0, 1'b1, d, ext, line, rr);
    chk(ext && !line, "R1 disabled cacheable goes single", {30'd0, ext, line}, 32'd2);
    chk(d == memf(32'h0000_1008), "R1 disabled data", d, memf(32'h0000_1008));
    access(32'h0000_1008, 1'b0, 1'b1, d, ext, line, rr);
    chk(ext, "R8 disabled repeat goes external", 32'(ext), 32'd1);

    cfg(1'b0, 1'b1, 2'b00);
    cfg(1'b1, 1'b0, 2'b01);

    // Table walk (fill-size 01)
    for (int i = 0; i < NV; i++) begin
      logic [31:0] a;
      a = VEC[i][35:4];
      access(a, VEC[i][3], VEC[i][2], d, ext, line, rr);
      chk(d == memf(a), $sformatf("R3/R7 vec%0d data", i), d, memf(a));
      chk(ext == VEC[i][1], $sformatf("R4/R5/R8 vec%0d external", i), 32'(ext), 32'(VEC[i][1]));
      if (VEC[i][1]) begin
        chk(line == VEC[i][0], $sformatf("R4/R5 vec%0d size", i), 32'(line), 32'(VEC[i][0]));
        chk(last_addr == {a[31:2], 2'b00}, $sformatf("R6 vec%0d mem addr", i), last_addr, {a[31:2], 2'b00});
        if (line) chk(rr == 1'b0, $sformatf("R9/R10 vec%0d forward before end", i), 32'(rr), 32'd0);
      end
    end

    // R5 fill-size 1x
    cfg(1'b1, 1'b0, 2'b10);
    access(32'h0000_7008, 1'b1, 1'b1, d, ext, line, rr);
    chk(ext && !line, "R5 fsz 1x offset 2 single", {30'd0, ext, line}, 32'd2);
    access(32'h0000_7104, 1'b1, 1'b1, d, ext, line, rr);
    chk(ext && line, "R5 fsz 1x offset 1 line", {30'd0, ext, line}, 32'd3);

    // R5/R6 fill-size 00 at offset 3, then wrapped order via hits
    cfg(1'b1, 1'b0, 2'b00);
    access(32'h0000_723C, 1'b1, 1'b1, d, ext, line, rr);
    chk(ext && line, "R5 fsz 00 offset 3 line", {30'd0, ext, line}, 32'd3);
    chk(last_addr == 32'h0000_723C, "R6 critical address", last_addr, 32'h0000_723C);
    chk(d == memf(32'h0000_723C), "R9 critical word data", d, memf(32'h0000_723C));
    chk(rr == 1'b0, "R10 stalled at forward", 32'(rr), 32'd0);
    for (int w = 0; w < 4; w++) begin
      logic [31:0] a;
      a = 32'h0000_7230 + 32'(w * 4);
      access(a, 1'b0, 1'b1, d, ext, line, rr);
      chk(!ext, $sformatf("R6 wrapped word %0d hits", w), 32'(ext), 32'd0);
      chk(d == memf(a), $sformatf("R6 wrapped word %0d data", w), d, memf(a));
    end

    // R2 invalidate while idle
    cfg(1'b1, 1'b1, 2'b00);
    access(32'h0000_7234, 1'b0, 1'b1, d, ext, line, rr);
    chk(ext && line, "R2 invalidated line refetched", {30'd0, ext, line}, 32'd3);

    // R11 invalidate during a line read
    begin
      int g = 0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_7540; req_instr = 1'b0; req_cacheable = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!mem_rvalid && g < 200) begin @(negedge clk); g++; end
      cfg_we = 1'b1; cfg_enable_in = 1'b1; cfg_inval_in = 1'b1; cfg_fsz_in = 2'b00;
      @(negedge clk);
      cfg_we = 1'b0; cfg_inval_in = 1'b0;
      chk(rsp_valid && rsp_data == memf(32'h0000_7540), "R11 read still answers", rsp_data, memf(32'h0000_7540));
      while (!req_ready && g < 400) begin @(negedge clk); g++; end
      chk(g < 400, "R11 read completes", 32'(g), 32'd0);
    end
    access(32'h0000_7544, 1'b0, 1'b1, d, ext, line, rr);
    chk(ext, "R11 line left invalid", 32'(ext), 32'd1);
    chk(d == memf(32'h0000_7544), "R11 refetch data", d, memf(32'h0000_7544));

    // R8 disabled ignores a valid line
    cfg(1'b0, 1'b0, 2'b00);
    access(32'h0000_7548, 1'b0, 1'b1, d, ext, line, rr);
    chk(ext && !line, "R8 disabled bypasses valid line", {30'd0, ext, line}, 32'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule